// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Unit

This unit gathers interrupt requests from up to twelve sources that sit at fixed positions in a 16-bit word. It shows them in a status register and masks them with a per-source enable register. Both registers live on a small processor register bus: a one-bit register address, a write strobe, write data and combinational read data.

Sources come in two kinds. Level sources are shown live in the status register. Event sources are latched when their input is high for a cycle, and software clears them by writing ones. A single request output goes high when any enabled source is pending. A vector index names the winning bit under a fixed priority, from bit 15 (highest) down to bit 0.

The debug interrupt at bit 15 can be made to bypass its enable bit. A configuration input from the debug controller selects this.

Top module: `irq_mask_unit`

## Requirements
- R1: Bit positions 14, 11, 7 and 6 are reserved. They read as 0 in both registers and ignore writes. Implemented positions give a mask of 0xB73F.
- R2: A write with `reg_addr`=0 stores `wr_data` (implemented bits only) into the enable register. A read with `reg_addr`=0 returns it.
- R3: Status bits 15, 10, 9, 3, 2, 1 and 0 are level bits. Each reads as its current `src_i` bit in the same cycle, and a write to it has no effect.
- R4: Status bits 13, 12, 8, 5 and 4 are event bits. An event bit becomes 1 on the clock edge that samples its `src_i` bit high, and stays 1 after the input falls.
- R5: A write with `reg_addr`=1 clears each event bit whose `wr_data` bit is 1, at that clock edge. A 0 in `wr_data` leaves the bit unchanged.
- R6: When an event input is high in the same cycle as a write of 1 to its bit, the bit stays 1.
- R7: `irq_o` is 1 exactly when some status bit and its matching enable bit are both 1. It is also 1 under the condition of R8.
- R8: When `dbg_unmask` is 1, status bit 15 raises `irq_o` whatever enable bit 15 holds.
- R9: `irq_vec_o` gives the index of the highest requesting bit, with 15 the highest priority and 0 the lowest. It is 0 when `irq_o` is 0.
- R10: After reset the enable register and all event bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 16 | Source inputs at status bit positions |
| dbg_unmask | input | 1 | Makes the debug interrupt ignore its enable bit |
| reg_addr | input | 1 | Register select: 0 enable, 1 status |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 4 | Index of the winning source |

## Verification
The bench builds the unit with the debug source present (`DBG_PRESENT`=1). That default brings the unmaskable path and the top-priority bit 15 into reach. Random source patterns mix level bits and sparse event pulses with random writes to both registers. This exercises priority contests between every pair of implemented bits, as well as the cases where setting and clearing an event bit collide. Directed steps cover the reserved holes, writes of zero to event bits, and the unmask switch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 16;
  localparam int IDX_W = 4;
  // event (latched, write-one-clear) positions: 13,12,8,5,4
  localparam logic [REG_W-1:0] EVT_MASK  = 16'h3130;
  // level positions other than debug: 10,9,3,2,1,0
  localparam logic [REG_W-1:0] LVL_MASK  = 16'h060F;
  localparam int DBG_BIT = 15;

  function automatic logic [REG_W-1:0] impl_mask(input bit dbg);
    logic [REG_W-1:0] m;
    m = EVT_MASK | LVL_MASK;
    if (dbg) m[DBG_BIT] = 1'b1;
    return m;
  endfunction

  // highest set bit wins; returns 0 when none
  function automatic logic [IDX_W-1:0] top_index(input logic [REG_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < REG_W; i++)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank import irq_pkg::*; #(
  parameter int W = REG_W,
  parameter logic [W-1:0] MASK = EVT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        q <= 1'b0;
        else if (set_i[b]) q <= 1'b1;   // new event beats a clear
        else if (clr_i[b]) q <= 1'b0;
      assign pend_o[b] = q;
    end else begin : g_none
      assign pend_o[b] = 1'b0;
    end
  end

  // R4: a sampled event is held
  a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_i & MASK) |=> ((pend_o & $past(set_i & MASK)) == $past(set_i & MASK)));
  // R5: a clear without a competing event empties the bit
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_i & ~set_i & MASK) |=> ((pend_o & $past(clr_i & ~set_i & MASK)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc import irq_pkg::*; #(
  parameter int W = REG_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  assign any_o = |req_i;
  assign idx_o = top_index(req_i);

  // R9: winner is set and nothing above it is
  a_r9_winner_is_top: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((req_i >> idx_o) == W'(1)));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (idx_o == '0));
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit import irq_pkg::*; #(
  parameter bit DBG_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_i,
  input  logic             dbg_unmask,
  input  logic             reg_addr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_o,
  output logic [IDX_W-1:0] irq_vec_o
);
  localparam logic [REG_W-1:0] VALID = impl_mask(DBG_PRESENT);
  localparam logic [REG_W-1:0] LIVE  = VALID & ~EVT_MASK;

  logic [REG_W-1:0] en_q, pend_evt, status, req;
  logic             wr_enable, wr_status;

  assign wr_enable = wr_en && !reg_addr;
  assign wr_status = wr_en &&  reg_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= wr_data & VALID;

  irq_event_bank #(.W(REG_W), .MASK(EVT_MASK)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .set_i (src_i & EVT_MASK),
    .clr_i (wr_status ? (wr_data & EVT_MASK) : '0),
    .pend_o(pend_evt)
  );

  assign status = (src_i & LIVE) | pend_evt;

  always_comb begin
    req = status & en_q;
    if (DBG_PRESENT && dbg_unmask) req[DBG_BIT] = status[DBG_BIT];
  end

  irq_prio_enc #(.W(REG_W), .IW(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .any_o(irq_o), .idx_o(irq_vec_o)
  );

  assign rd_data = reg_addr ? status : en_q;

  // R1: reserved positions never read back as 1
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~VALID) == '0);
  // R2: enable write lands
  a_r2_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_addr) |=> (en_q == $past(wr_data & VALID)));
  // R3: level bits track the live input
  a_r3_level_live: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> ((rd_data & LIVE) == (src_i & LIVE)));
  // R8: unmaskable debug source wins outright
  a_r8_dbg_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (DBG_PRESENT && dbg_unmask && src_i[DBG_BIT]) |-> (irq_o && irq_vec_o == IDX_W'(DBG_BIT)));
endmodule

// File: tb/sim_irq_mask_unit.sv
module sim_irq_mask_unit;
  logic        clk = 0, rst_n = 0;
  logic [15:0] src_i = '0, wr_data = '0, rd_data;
  logic        dbg_unmask = 0, reg_addr = 0, wr_en = 0, irq_o;
  logic [3:0]  irq_vec_o;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] en_m = '0, pend_m = '0;

  localparam logic [15:0] M_VALID = 16'hB73F;
  localparam logic [15:0] M_EVT   = 16'h3130;

  irq_mask_unit u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .dbg_unmask(dbg_unmask),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o));

  always #5 clk = ~clk;

  function automatic logic [15:0] exp_status(input logic [15:0] s, input logic [15:0] p);
    return (s & M_VALID & ~M_EVT) | p;
  endfunction
  function automatic logic [15:0] exp_req(input logic [15:0] st, input logic [15:0] e, input logic u);
    logic [15:0] r;
    r = st & e;
    if (u && st[15]) r[15] = 1'b1;
    return r;
  endfunction
  function automatic logic [3:0] exp_idx(input logic [15:0] r);
    for (int i = 15; i >= 0; i--) if (r[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // inputs are driven at negedge; combinational outputs checked, then model advances
  task automatic step(input logic [15:0] s, input logic u, input logic a,
                      input logic we, input logic [15:0] wd);
    logic [15:0] st, rq;
    src_i = s; dbg_unmask = u; reg_addr = a; wr_en = we; wr_data = wd;
    #1;
    st = exp_status(s, pend_m);
    rq = exp_req(st, en_m, u);
    check(a ? "R3 status read" : "R2 enable read", rd_data, a ? st : en_m);
    check("R7 irq_o", 16'(irq_o), 16'(|rq));
    check("R9 vector", 16'(irq_vec_o), 16'(exp_idx(rq)));
    if (we && !a) en_m = wd & M_VALID;
    pend_m = (pend_m & ~((we && a) ? (wd & M_EVT) : 16'h0)) | (s & M_EVT);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    #1 check("R10 enable after reset", rd_data, 16'h0);
    reg_addr = 1; #1 check("R10 status after reset", rd_data, 16'h0);
    check("R10 irq after reset", 16'(irq_o), 16'h0);
    @(negedge clk);
    // R1/R2: full write keeps only implemented bits
    step(16'h0, 0, 0, 1, 16'hFFFF);
    step(16'h0, 0, 0, 0, 16'h0);
    check("R1 reserved masked in enable", rd_data, 16'hB73F);
    // R1: reserved source inputs never appear
    step(16'h48C0, 0, 1, 0, 16'h0);
    // R4: pulse on bit 8, then idle
    step(16'h0100, 0, 1, 0, 16'h0);
    step(16'h0000, 0, 1, 0, 16'h0);
    check("R4 event held", rd_data, 16'h0100);
    check("R9 vector 8", 16'(irq_vec_o), 16'd8);
    // R5: writing zero there does nothing
    step(16'h0000, 0, 1, 1, 16'hFEFF);
    step(16'h0000, 0, 1, 0, 16'h0);
    check("R5 zero write no effect", rd_data, 16'h0100);
    // R6: set and clear together
    step(16'h0100, 0, 1, 1, 16'h0100);
    step(16'h0000, 0, 1, 0, 16'h0);
    check("R6 set beats clear", rd_data, 16'h0100);
    // R5: clear with ones
    step(16'h0000, 0, 1, 1, 16'h0100);
    step(16'h0000, 0, 1, 0, 16'h0);
    check("R5 cleared", rd_data, 16'h0000);
    // R3: level bit follows and ignores writes
    step(16'h0008, 0, 1, 1, 16'h0008);
    step(16'h0008, 0, 1, 0, 16'h0);
    check("R3 level live", rd_data, 16'h0008);
    step(16'h0000, 0, 1, 0, 16'h0);
    check("R3 level dropped", rd_data, 16'h0000);
    // R8: debug source masked off, then unmaskable
    step(16'h0000, 0, 0, 1, 16'h0000);
    step(16'h8000, 0, 1, 0, 16'h0);
    check("R8 masked debug quiet", 16'(irq_o), 16'h0);
    step(16'h8004, 1, 1, 0, 16'h0);
    check("R8 unmasked debug", 16'(irq_o), 16'h1);
    check("R8 debug vector", 16'(irq_vec_o), 16'd15);
    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [15:0] s, wd;
      s  = 16'($urandom) & ~M_EVT;
      if ($urandom_range(0, 3) == 0) s = s | (16'($urandom) & M_EVT);
      wd = 16'($urandom);
      step(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3) == 0, wd);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule